// File: doc/BRIEF.md
# Cache Tag Walk Engine

This block sweeps the tag array of a cache whose tags sit in an ordinary synchronous RAM, one that cannot clear state bits across all lines in a single cycle. When a commit or a rollback is requested, the engine stalls the pipeline. It then reads every line in ascending order and writes back a corrected copy of each line whose state bits must change. It finishes with a single restore cycle and then releases the stall.

Each tag word holds three fields. The valid bit is at bit `ADDR_TAG_W+2`. A two-bit epoch field is at bits `ADDR_TAG_W+1:ADDR_TAG_W`. The address tag occupies bits `ADDR_TAG_W-1:0`. Epoch value 0 marks a committed line. Values 1 and 2 name the two speculative epochs. A commit carries a two-bit epoch selector: bit 0 selects epoch 1 and bit 1 selects epoch 2, so one sweep can retire either epoch or both. A rollback discards all speculative lines at once. The RAM has one read port and one write port, and a line's read data returns one cycle after its read.

Top module: `cw_walk_engine`

## Requirements
- R1: While reset is held, `stall_o`, `done_o`, `tag_rd_o` and `tag_wr_o` are all low.
- R2: A request seen at a clock edge while the engine is idle raises `stall_o` in the next cycle. In that same cycle the engine reads line 0.
- R3: A sweep issues exactly `NUM_LINES` reads, one per cycle, at addresses 0, 1, ..., `NUM_LINES-1` in order. The index does not wrap, and no further read follows the last line.
- R4: A line is written only in the cycle right after its read, at the same address, and only when its new value differs from the value read.
- R5: On commit, a line whose epoch field is 1 (selector bit 0 set) or 2 (selector bit 1 set) gets epoch field 0, and its valid bit and address tag are kept. All other lines, including those with epoch field 3, are unchanged.
- R6: A selector of 2'b11 retires both epochs in one sweep. A selector of 2'b00 changes no line.
- R7: On rollback, every line whose epoch field is nonzero gets valid bit 0 and epoch field 0. Lines with epoch field 0 are unchanged.
- R8: After the last write slot there is one restore cycle in which `done_o` and `stall_o` are both high and no RAM access occurs. `stall_o` falls in the next cycle. The stall therefore lasts `NUM_LINES+2` cycles.
- R9: `done_o` is high for exactly one cycle per sweep.
- R10: Requests that arrive while the engine is busy are held in one pending slot and served by a single sweep after `done_o`. Pending commits merge their selectors by OR. A rollback replaces any pending commit. A rollback and a commit in the same cycle act as a rollback.
- R11: Every write keeps the address tag field of the line as it was read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| commit_req_i | input | 1 | Commit request, sampled each cycle |
| rollback_req_i | input | 1 | Rollback request, sampled each cycle |
| epoch_sel_i | input | 2 | Commit epoch selector (bit 0: epoch 1, bit 1: epoch 2) |
| stall_o | output | 1 | Pipeline stall, high while a sweep is in progress |
| done_o | output | 1 | One-cycle pulse in the restore cycle |
| tag_rd_o | output | 1 | Tag RAM read enable |
| tag_raddr_o | output | IDX_W | Tag RAM read address |
| tag_rdata_i | input | TAG_W | Tag RAM read data, valid one cycle after a read |
| tag_wr_o | output | 1 | Tag RAM write enable |
| tag_waddr_o | output | IDX_W | Tag RAM write address |
| tag_wdata_o | output | TAG_W | Tag RAM write data |

## Verification
The assertions assume that the tag RAM returns the addressed word exactly one cycle after a read. They also assume that no other agent writes the tags while `stall_o` is high. The bench models the RAM with that latency, and it changes the tag contents only while the engine is idle. Request pulses are driven between clock edges, and busy-time requests are placed in the middle of a sweep. Random epoch fields include the value 3 so that the commit and rollback rules for that value are also exercised.

// File: rtl/cw_pkg.sv
package cw_pkg;

  typedef enum logic [1:0] {
    OP_NONE     = 2'd0,
    OP_COMMIT   = 2'd1,
    OP_ROLLBACK = 2'd2
  } walk_op_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WALK    = 2'd1,
    ST_RESTORE = 2'd2
  } walk_state_e;

  typedef struct packed {
    walk_op_e   op;
    logic [1:0] mask;
  } walk_req_t;

  localparam walk_req_t REQ_NONE = '{op: OP_NONE, mask: 2'b00};

  // rollback dominates; commits merge their selectors
  function automatic walk_req_t merge_req(walk_req_t a, walk_req_t b);
    walk_req_t r;
    r = REQ_NONE;
    if (a.op == OP_ROLLBACK || b.op == OP_ROLLBACK) begin
      r.op = OP_ROLLBACK;
    end else if (a.op == OP_COMMIT || b.op == OP_COMMIT) begin
      r.op   = OP_COMMIT;
      r.mask = (a.op == OP_COMMIT ? a.mask : 2'b00) |
               (b.op == OP_COMMIT ? b.mask : 2'b00);
    end
    return r;
  endfunction

endpackage

// File: rtl/cw_req_latch.sv
module cw_req_latch
  import cw_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      busy_i,
  input  walk_req_t new_req_i,
  output walk_req_t eff_req_o
);

  walk_req_t pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= REQ_NONE;
    else if (!busy_i) pend_q <= REQ_NONE;
    else              pend_q <= merge_req(pend_q, new_req_i);
  end

  assign eff_req_o = merge_req(pend_q, new_req_i);

  // R10: a held rollback is never downgraded while busy
  p_pend_rb_kept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && pend_q.op == OP_ROLLBACK) |=> (pend_q.op == OP_ROLLBACK || !$past(busy_i) || !busy_i));

endmodule

// File: rtl/cw_index_ctr.sv
module cw_index_ctr #(
  parameter int unsigned NUM_LINES = 16,
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             active_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

  logic             active_q;
  logic [IDX_W-1:0] idx_q;

  assign last_o   = active_q && (idx_q == LAST_IDX);
  assign active_o = active_q;
  assign idx_o    = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (active_q) begin
      if (last_o) active_q <= 1'b0;   // stop, no wrap
      else        idx_q    <= idx_q + 1'b1;
    end
  end

  p_ctr_stops_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !active_o);

  p_ctr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !last_o && !start_i) |=> (active_o && idx_o == $past(idx_o) + 1'b1));

endmodule

// File: rtl/cw_line_xform.sv
module cw_line_xform
  import cw_pkg::*;
#(
  parameter int unsigned ADDR_TAG_W = 8,
  localparam int unsigned TAG_W = ADDR_TAG_W + 3,
  localparam int unsigned VLD_BIT = ADDR_TAG_W + 2,
  localparam int unsigned EP_LO = ADDR_TAG_W
) (
  input  walk_op_e         op_i,
  input  logic [1:0]       mask_i,
  input  logic [TAG_W-1:0] old_i,
  output logic [TAG_W-1:0] new_o,
  output logic             changed_o
);

  logic [1:0] epoch;
  logic       hit_commit;

  assign epoch      = old_i[EP_LO+1:EP_LO];
  assign hit_commit = (epoch == 2'd1 && mask_i[0]) || (epoch == 2'd2 && mask_i[1]);

  always_comb begin
    new_o = old_i;
    unique case (op_i)
      OP_COMMIT: if (hit_commit) new_o[EP_LO+1:EP_LO] = 2'b00;
      OP_ROLLBACK: if (epoch != 2'b00) begin
        new_o[VLD_BIT]          = 1'b0;
        new_o[EP_LO+1:EP_LO]    = 2'b00;
      end
      default: new_o = old_i;
    endcase
  end

  assign changed_o = (new_o != old_i);

endmodule

// File: rtl/cw_walk_engine.sv
module cw_walk_engine
  import cw_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 16,
  parameter int unsigned ADDR_TAG_W = 8,
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int unsigned TAG_W = ADDR_TAG_W + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_req_i,
  input  logic             rollback_req_i,
  input  logic [1:0]       epoch_sel_i,
  output logic             stall_o,
  output logic             done_o,
  output logic             tag_rd_o,
  output logic [IDX_W-1:0] tag_raddr_o,
  input  logic [TAG_W-1:0] tag_rdata_i,
  output logic             tag_wr_o,
  output logic [IDX_W-1:0] tag_waddr_o,
  output logic [TAG_W-1:0] tag_wdata_o
);

  localparam int unsigned VLD_BIT = ADDR_TAG_W + 2;
  localparam int unsigned EP_LO   = ADDR_TAG_W;

  walk_state_e      state_q;
  walk_req_t        new_req, eff_req;
  walk_op_e         op_q;
  logic [1:0]       mask_q;
  logic             start;
  logic             rd_active, rd_last;
  logic [IDX_W-1:0] rd_idx;
  logic             wr_pend_q;
  logic [IDX_W-1:0] wr_idx_q;
  logic [TAG_W-1:0] new_line;
  logic             line_changed;

  always_comb begin
    new_req = REQ_NONE;
    if (rollback_req_i)    new_req.op = OP_ROLLBACK;
    else if (commit_req_i) new_req = '{op: OP_COMMIT, mask: epoch_sel_i};
  end

  cw_req_latch u_req (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_i    (state_q != ST_IDLE),
    .new_req_i (new_req),
    .eff_req_o (eff_req)
  );

  assign start = (state_q == ST_IDLE) && (eff_req.op != OP_NONE);

  cw_index_ctr #(.NUM_LINES(NUM_LINES)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .active_o (rd_active),
    .last_o   (rd_last),
    .idx_o    (rd_idx)
  );

  cw_line_xform #(.ADDR_TAG_W(ADDR_TAG_W)) u_xf (
    .op_i      (op_q),
    .mask_i    (mask_q),
    .old_i     (tag_rdata_i),
    .new_o     (new_line),
    .changed_o (line_changed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      op_q      <= OP_NONE;
      mask_q    <= 2'b00;
      wr_pend_q <= 1'b0;
      wr_idx_q  <= '0;
    end else begin
      wr_pend_q <= rd_active;
      wr_idx_q  <= rd_idx;
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_WALK;
          op_q    <= eff_req.op;
          mask_q  <= eff_req.mask;
        end
        ST_WALK: if (wr_pend_q && !rd_active) state_q <= ST_RESTORE;
        ST_RESTORE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign stall_o     = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_RESTORE);
  assign tag_rd_o    = rd_active;
  assign tag_raddr_o = rd_idx;
  assign tag_wr_o    = wr_pend_q && line_changed;
  assign tag_waddr_o = wr_idx_q;
  assign tag_wdata_o = new_line;

  p_req_stalls_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && (commit_req_i || rollback_req_i)) |=> stall_o);

  p_first_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |-> (tag_rd_o && tag_raddr_o == '0));

  p_wr_after_rd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_wr_o |-> ($past(tag_rd_o) && tag_waddr_o == $past(tag_raddr_o)));

  p_wr_changes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_wr_o |-> (tag_wdata_o != tag_rdata_i));

  p_commit_keeps_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_wr_o && op_q == OP_COMMIT) |->
      (tag_wdata_o[VLD_BIT] == tag_rdata_i[VLD_BIT] && tag_wdata_o[EP_LO+1:EP_LO] == 2'b00));

  p_rb_invalidates_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_wr_o && op_q == OP_ROLLBACK) |->
      (!tag_wdata_o[VLD_BIT] && tag_wdata_o[EP_LO+1:EP_LO] == 2'b00 && tag_rdata_i[EP_LO+1:EP_LO] != 2'b00));

  p_restore_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (stall_o && !tag_rd_o && !tag_wr_o));

  p_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !stall_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_tag_kept_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_wr_o |-> (tag_wdata_o[ADDR_TAG_W-1:0] == tag_rdata_i[ADDR_TAG_W-1:0]));

  p_rd_in_walk_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_rd_o || rd_last) |-> (state_q == ST_WALK));

endmodule

// File: tb/cw_walk_engine_test.sv
module cw_walk_engine_test;
  localparam int N  = 16;
  localparam int AT = 8;
  localparam int IW = 4;
  localparam int TW = AT + 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic commit_req = 1'b0, rollback_req = 1'b0;
  logic [1:0] epoch_sel = 2'b00;
  logic stall, done, tag_rd, tag_wr;
  logic [IW-1:0] raddr, waddr;
  logic [TW-1:0] rdata, wdata;

  logic [TW-1:0] mem [N];
  logic [TW-1:0] ref_mem [N];

  int n_checks = 0, n_errors = 0;
  int exp_rd = 0, rd_cnt = 0, wr_cnt = 0, run = 0, done_cnt = 0;
  logic prev_rd = 1'b0, prev_done = 1'b0, prev_stall = 1'b0;
  logic [IW-1:0] prev_raddr = '0;

  always #4 clk = ~clk;

  cw_walk_engine #(.NUM_LINES(N), .ADDR_TAG_W(AT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .commit_req_i(commit_req), .rollback_req_i(rollback_req),
    .epoch_sel_i(epoch_sel), .stall_o(stall), .done_o(done), .tag_rd_o(tag_rd),
    .tag_raddr_o(raddr), .tag_rdata_i(rdata), .tag_wr_o(tag_wr), .tag_waddr_o(waddr),
    .tag_wdata_o(wdata));

  always @(posedge clk) begin
    if (tag_rd) rdata <= mem[raddr];
    if (tag_wr) mem[waddr] <= wdata;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] exp_line(bit rb, logic [1:0] m, logic [TW-1:0] old);
    logic [1:0] ep;
    ep = old[AT+1:AT];
    if (rb) return (ep != 2'd0) ? {1'b0, 2'b00, old[AT-1:0]} : old;
    if ((ep == 2'd1 && m[0]) || (ep == 2'd2 && m[1])) return {old[AT+2], 2'b00, old[AT-1:0]};
    return old;
  endfunction

  // port monitor
  always @(negedge clk) if (rst_n) begin
    if (stall && !prev_stall) begin exp_rd = 0; rd_cnt = 0; wr_cnt = 0; end
    if (tag_rd) begin
      check(raddr == IW'(exp_rd), "R3 read order", raddr, exp_rd);
      exp_rd++; rd_cnt++;
    end
    if (tag_wr) begin
      wr_cnt++;
      check(prev_rd && waddr == prev_raddr, "R4 write slot", waddr, prev_raddr);
      check(wdata != mem[waddr], "R4 write only on change", wdata, mem[waddr]);
      check(wdata[AT-1:0] == mem[waddr][AT-1:0], "R11 address tag kept", wdata[AT-1:0], mem[waddr][AT-1:0]);
    end
    if (done) begin
      done_cnt++;
      check(!prev_done, "R9 done one cycle", 1, 0);
      check(!tag_rd && !tag_wr && stall, "R8 restore cycle quiet", {tag_rd, tag_wr, stall}, 1);
    end
    if (stall) run++;
    else if (run != 0) begin
      check(run == N + 2, "R8 stall length", run, N + 2);
      check(rd_cnt == N, "R3 read count", rd_cnt, N);
      run = 0;
    end
    prev_rd = tag_rd; prev_raddr = raddr; prev_done = done; prev_stall = stall;
  end

  task automatic apply_ref(bit rb, logic [1:0] m);
    for (int i = 0; i < N; i++) ref_mem[i] = exp_line(rb, m, ref_mem[i]);
  endtask

  task automatic fill(int kind);
    for (int i = 0; i < N; i++) begin
      logic [TW-1:0] v;
      v = TW'($urandom);
      if (kind == 1) v[AT+1:AT] = 2'b00;
      if (kind == 2) v[AT+1:AT] = 2'(1 + (i % 2));
      mem[i] = v; ref_mem[i] = v;
    end
  endtask

  task automatic pulse(bit c, bit r, logic [1:0] m);
    commit_req = c; rollback_req = r; epoch_sel = m;
    @(negedge clk);
    commit_req = 1'b0; rollback_req = 1'b0; epoch_sel = 2'b00;
  endtask

  task automatic wait_done_count(int target);
    int t = 0;
    while (done_cnt < target && t < 400) begin @(negedge clk); t++; end
    check(done_cnt >= target, "R8 sweep finishes", done_cnt, target);
    repeat (3) @(negedge clk);
  endtask

  task automatic compare(string req);
    int bad = 0, first = -1;
    for (int i = 0; i < N; i++) if (mem[i] !== ref_mem[i]) begin bad++; if (first < 0) first = i; end
    if (first < 0) first = 0;
    check(bad == 0, req, mem[first], ref_mem[first]);
  endtask

  task automatic walk(bit rb, logic [1:0] m, string req);
    int d0;
    d0 = done_cnt;
    apply_ref(rb, m);
    pulse(!rb, rb, m);
    check(stall && tag_rd && raddr == '0, "R2 stall and read line 0", {stall, tag_rd}, 3);
    wait_done_count(d0 + 1);
    check(done_cnt == d0 + 1, "R9 one done per sweep", done_cnt - d0, 1);
    compare(req);
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (2) @(negedge clk);
    check(!stall && !done && !tag_rd && !tag_wr, "R1 reset outputs", {stall, done, tag_rd, tag_wr}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    fill(2); walk(1'b0, 2'b01, "R5 commit epoch 1");
    fill(2); walk(1'b0, 2'b10, "R5 commit epoch 2");
    fill(0); walk(1'b0, 2'b11, "R6 commit both epochs");
    fill(0); walk(1'b0, 2'b00, "R6 empty selector");
    check(wr_cnt == 0, "R6 empty selector writes nothing", wr_cnt, 0);
    fill(1); walk(1'b1, 2'b00, "R7 rollback on committed lines");
    check(wr_cnt == 0, "R4 no write for unchanged lines", wr_cnt, 0);
    fill(0); walk(1'b1, 2'b00, "R7 rollback");

    for (int k = 0; k < 10; k++) begin
      int sel;
      sel = $urandom_range(0, 3);
      if (k % 3 == 0) fill(0);
      walk(sel == 3, 2'(sel), sel == 3 ? "R7 random rollback" : "R5 random commit");
    end

    // R10: merge of two pending commits
    begin
      int d0;
      fill(0); d0 = done_cnt;
      apply_ref(1'b0, 2'b00); apply_ref(1'b0, 2'b11);
      pulse(1'b1, 1'b0, 2'b00);
      repeat (3) @(negedge clk); pulse(1'b1, 1'b0, 2'b01);
      repeat (2) @(negedge clk); pulse(1'b1, 1'b0, 2'b10);
      wait_done_count(d0 + 2);
      repeat (N + 4) @(negedge clk);
      check(done_cnt == d0 + 2, "R10 pending commits merged", done_cnt - d0, 2);
      compare("R10 merged commit result");
    end

    // R10: rollback replaces pending commit
    begin
      int d0;
      fill(0); d0 = done_cnt;
      apply_ref(1'b1, 2'b00);
      pulse(1'b1, 1'b0, 2'b00);
      repeat (4) @(negedge clk); pulse(1'b1, 1'b0, 2'b01);
      repeat (2) @(negedge clk); pulse(1'b0, 1'b1, 2'b00);
      wait_done_count(d0 + 2);
      repeat (N + 4) @(negedge clk);
      check(done_cnt == d0 + 2, "R10 pending rollback one sweep", done_cnt - d0, 2);
      compare("R10 rollback overrides commit");
    end

    // R10: simultaneous commit and rollback while idle
    fill(0);
    apply_ref(1'b1, 2'b00);
    begin
      int d0;
      d0 = done_cnt;
      pulse(1'b1, 1'b1, 2'b11);
      wait_done_count(d0 + 1);
      compare("R10 simultaneous request acts as rollback");
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule